// File: doc/BRIEF.md
# Interrupt Request Capture Front End

This block turns sixteen raw interrupt lines into the pending-request bits of two eight-input interrupt controllers. Lines 0 to 7 belong to the first controller and lines 8 to 15 to the second; within a controller the line's position is its number modulo eight. Each line is sampled every clock and compared with its value from the previous cycle. A line can be captured on its rising edge or tracked as a level, and a per-line trigger-mode bit selects which.

The trigger-mode bits are held in one byte per controller. Each byte can be written and read back. A few lines are wired to stay in edge mode, and writes cannot change that. When the downstream priority logic accepts an interrupt, it sends an acknowledge that names the controller and the pin. That acknowledge retires the pending bit, but only while the line is low.

Top module: `irq_capture_top`

## Requirements
- R1: A 0-to-1 change on any line, seen against the previous cycle's sample, sets that line's request bit one clock later. Request bit k of `reqOut` belongs to line k, so controller c owns bits 8c+7 to 8c.
- R2: While a line in level mode (trigger bit 1) is high, its request bit reads 1 from the clock after it is sampled high. An acknowledge does not clear it.
- R3: When a level-mode line goes from 1 to 0, its request bit is 0 one clock later.
- R4: When an edge-mode line (trigger bit 0) goes from 1 to 0, its request bit stays 1 until an acknowledge retires it.
- R5: An acknowledge clears the addressed request bit at the next clock only if the addressed line is currently low. An acknowledge of a high line leaves the bit at 1.
- R6: A write of byte X to trigger byte 0 (`trigSel`=0) stores X AND 0xF8, so lines 0, 1 and 2 read back 0 and stay in edge mode.
- R7: A write of byte X to trigger byte 1 (`trigSel`=1) stores X AND 0xDE, so lines 8 and 13 read back 0 and stay in edge mode.
- R8: A line that is high for a single clock on an edge-mode line leaves its request bit set after the line returns low.
- R9: After reset all request bits are 0 and both trigger bytes read 0, so every line starts in edge mode.
- R10: An acknowledge with `ackCtrl`=c and `ackPin`=p addresses line 8c+p only. It has no effect on any other request bit.
- R11: A write to a trigger byte takes effect at the next clock edge. Reads through `trigRdSel` return the stored byte combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 16 | Raw interrupt lines, line k on bit k |
| trigWrEn | input | 1 | Write strobe for a trigger-mode byte |
| trigSel | input | 1 | Controller whose trigger byte is written |
| trigWrData | input | 8 | Trigger byte to write (1 = level mode) |
| trigRdSel | input | 1 | Controller whose trigger byte is read |
| trigRdData | output | 8 | Stored trigger byte of the selected controller |
| ackEn | input | 1 | Acknowledge strobe from priority logic |
| ackCtrl | input | 1 | Controller being acknowledged |
| ackPin | input | 3 | Pin within that controller |
| reqOut | output | 16 | Pending request bits, line k on bit k |

## Verification
The bench builds the block with its defaults: two controllers of eight lines each, and a forced-edge pattern covering lines 0, 1, 2, 8 and 13. With these values both write masks come into play. The boundary between the two controllers is also exercised: an acknowledge for pin 0 of the second controller must touch line 8 and never line 0. Random toggling under both trigger modes, mixed with random acknowledges, covers acknowledges that land on high lines and on low lines. It also covers edges that arrive in the same cycle as a trigger-byte write.

// File: rtl/irq_cap_pkg.sv
package irq_cap_pkg;
  localparam int unsigned CTRL_CNT    = 2;
  localparam int unsigned LINES_PER   = 8;
  localparam int unsigned TOTAL_LINES = CTRL_CNT * LINES_PER;
  localparam int unsigned CTRL_IDX_W  = (CTRL_CNT > 1) ? $clog2(CTRL_CNT) : 1;
  localparam int unsigned PIN_IDX_W   = (LINES_PER > 1) ? $clog2(LINES_PER) : 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic [CTRL_CNT-1:0]    trigWr;   // one-hot byte write enable
    logic [TOTAL_LINES-1:0] ackLine;  // one-hot acknowledged line
  } capStrobe_t;
endpackage

// File: rtl/irq_cap_ctrl.sv
module irq_cap_ctrl
  import irq_cap_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  trigWrEn,
  input  logic [CTRL_IDX_W-1:0] trigSel,
  input  logic                  ackEn,
  input  logic [CTRL_IDX_W-1:0] ackCtrl,
  input  logic [PIN_IDX_W-1:0]  ackPin,
  output capStrobe_t            strobes
);

  for (genvar c = 0; c < CTRL_CNT; c++) begin : g_wr
    assign strobes.trigWr[c] = trigWrEn && (trigSel == CTRL_IDX_W'(c));
  end

  for (genvar i = 0; i < TOTAL_LINES; i++) begin : g_ack
    assign strobes.ackLine[i] = ackEn
                             && (ackCtrl == CTRL_IDX_W'(i / LINES_PER))
                             && (ackPin  == PIN_IDX_W'(i % LINES_PER));
  end

  // R10: an acknowledge targets at most one line, and exactly one when strobed
  p_ack_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.ackLine) && (ackEn -> ($countones(strobes.ackLine) == 1)));

  // R11: a write strobe selects a single trigger byte
  p_wr_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.trigWr) && (trigWrEn -> ($countones(strobes.trigWr) == 1)));

endmodule

// File: rtl/irq_cap_datapath.sv
module irq_cap_datapath
  import irq_cap_pkg::*;
#(
  parameter logic [TOTAL_LINES-1:0] FORCED_EDGE = 16'h2107
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  capStrobe_t             strobes,
  input  logic [TOTAL_LINES-1:0] irqLines,
  input  logic [LINES_PER-1:0]   trigWrData,
  input  logic [CTRL_IDX_W-1:0]  trigRdSel,
  output logic [LINES_PER-1:0]   trigRdData,
  output logic [TOTAL_LINES-1:0] reqOut
);

  logic [TOTAL_LINES-1:0] lineQ;
  logic [TOTAL_LINES-1:0] levelMode;
  logic [TOTAL_LINES-1:0] reqQ;
  logic [TOTAL_LINES-1:0] reqNext;

  // Previous-cycle samples for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) lineQ <= '0;
    else       lineQ <= irqLines;
  end

  // Trigger-mode bytes; forced lines can never hold a 1
  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelMode <= '0;
    end else begin
      for (int c = 0; c < CTRL_CNT; c++) begin
        if (strobes.trigWr[c])
          levelMode[c*LINES_PER +: LINES_PER] <=
            trigWrData & ~FORCED_EDGE[c*LINES_PER +: LINES_PER];
      end
    end
  end

  always_comb begin
    trigRdData = '0;
    for (int c = 0; c < CTRL_CNT; c++) begin
      if (trigRdSel == CTRL_IDX_W'(c))
        trigRdData = levelMode[c*LINES_PER +: LINES_PER];
    end
  end

  for (genvar i = 0; i < TOTAL_LINES; i++) begin : g_line
    logic riseSeen, setReq, clrReq;
    assign riseSeen = irqLines[i] && !lineQ[i];
    assign setReq   = riseSeen || (irqLines[i] && levelMode[i]);
    assign clrReq   = (!irqLines[i] && lineQ[i] && levelMode[i])
                   || (strobes.ackLine[i] && !irqLines[i]);
    assign reqNext[i] = setReq ? 1'b1 : (clrReq ? 1'b0 : reqQ[i]);

    p_rise_sets_r1: assert property (@(posedge clk) disable iff (!rstN)
      (irqLines[i] && !lineQ[i]) |=> reqOut[i]);
    p_level_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
      (irqLines[i] && levelMode[i]) |=> reqOut[i]);
    p_level_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
      (!irqLines[i] && lineQ[i] && levelMode[i]) |=> !reqOut[i]);
    p_edge_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
      (reqOut[i] && !levelMode[i] && !strobes.ackLine[i]) |=> reqOut[i]);
    p_ack_busy_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.ackLine[i] && irqLines[i] && reqOut[i]) |=> reqOut[i]);
    p_ack_idle_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.ackLine[i] && !irqLines[i]) |=> !reqOut[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) reqQ <= '0;
    else       reqQ <= reqNext;
  end

  assign reqOut = reqQ;

  // R6/R7: stored trigger bits never cover a forced-edge line
  p_forced_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.trigWr != '0) |=> ((levelMode & FORCED_EDGE) == '0));

endmodule

// File: rtl/irq_capture_top.sv
module irq_capture_top
  import irq_cap_pkg::*;
#(
  parameter logic [TOTAL_LINES-1:0] FORCED_EDGE = 16'h2107
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [TOTAL_LINES-1:0] irqLines,
  input  logic                   trigWrEn,
  input  logic [CTRL_IDX_W-1:0]  trigSel,
  input  logic [LINES_PER-1:0]   trigWrData,
  input  logic [CTRL_IDX_W-1:0]  trigRdSel,
  output logic [LINES_PER-1:0]   trigRdData,
  input  logic                   ackEn,
  input  logic [CTRL_IDX_W-1:0]  ackCtrl,
  input  logic [PIN_IDX_W-1:0]   ackPin,
  output logic [TOTAL_LINES-1:0] reqOut
);

  capStrobe_t strobes;

  irq_cap_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .trigWrEn (trigWrEn),
    .trigSel  (trigSel),
    .ackEn    (ackEn),
    .ackCtrl  (ackCtrl),
    .ackPin   (ackPin),
    .strobes  (strobes)
  );

  irq_cap_datapath #(.FORCED_EDGE(FORCED_EDGE)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .irqLines   (irqLines),
    .trigWrData (trigWrData),
    .trigRdSel  (trigRdSel),
    .trigRdData (trigRdData),
    .reqOut     (reqOut)
  );

endmodule

// File: tb/irq_capture_top_tb.sv
`timescale 1ns/1ps
module irq_capture_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] irqLines;
  logic        trigWrEn;
  logic [0:0]  trigSel;
  logic [7:0]  trigWrData;
  logic [0:0]  trigRdSel;
  logic [7:0]  trigRdData;
  logic        ackEn;
  logic [0:0]  ackCtrl;
  logic [2:0]  ackPin;
  logic [15:0] reqOut;

  int nChecks = 0;
  int nFails  = 0;

  logic [15:0] expReq;
  logic [15:0] prevLines;
  logic [7:0]  expTrig [2];

  always #2.5 clk = ~clk;

  irq_capture_top dut_i (
    .clk(clk), .rstN(rstN), .irqLines(irqLines),
    .trigWrEn(trigWrEn), .trigSel(trigSel), .trigWrData(trigWrData),
    .trigRdSel(trigRdSel), .trigRdData(trigRdData),
    .ackEn(ackEn), .ackCtrl(ackCtrl), .ackPin(ackPin), .reqOut(reqOut)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] modelNext(input logic [15:0] cur, input logic [15:0] ln,
      input logic [15:0] prv, input logic [15:0] lvl, input logic [15:0] ack);
    logic [15:0] n;
    for (int i = 0; i < 16; i++) begin
      if (ln[i] && (!prv[i] || lvl[i]))                        n[i] = 1'b1;
      else if ((!ln[i] && prv[i] && lvl[i]) || (ack[i] && !ln[i])) n[i] = 1'b0;
      else                                                       n[i] = cur[i];
    end
    return n;
  endfunction

  function automatic logic [7:0] writeMask(input logic sel);
    return sel ? 8'hDE : 8'hF8;   // R6, R7
  endfunction

  // Drive one cycle from a negedge, check after the following posedge
  task automatic cycle(input logic [15:0] ln, input bit wr, input logic sel,
                       input logic [7:0] data, input bit ak, input logic actl,
                       input logic [2:0] apin, input string tag);
    logic [15:0] ackVec;
    irqLines = ln; trigWrEn = wr; trigSel = sel; trigWrData = data;
    ackEn = ak; ackCtrl = actl; ackPin = apin;
    ackVec = ak ? (16'h1 << (int'(actl) * 8 + int'(apin))) : 16'h0;
    expReq = modelNext(expReq, ln, prevLines, {expTrig[1], expTrig[0]}, ackVec);
    prevLines = ln;
    if (wr) expTrig[sel] = data & writeMask(sel);
    @(posedge clk);
    #1;
    check(reqOut === expReq, tag, reqOut, expReq);
    @(negedge clk);
    trigWrEn = 1'b0; ackEn = 1'b0;
  endtask

  task automatic readTrig(input logic sel, input string tag);
    trigRdSel = sel;
    #0.5;
    check(trigRdData === expTrig[sel], tag, {8'h0, trigRdData}, {8'h0, expTrig[sel]});
  endtask

  initial begin
    #(200000 * 5);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [15:0] ln;
    void'($urandom(32'h1234_5678));
    rstN = 1'b0; irqLines = '0; trigWrEn = 0; trigSel = 0; trigWrData = 0;
    trigRdSel = 0; ackEn = 0; ackCtrl = 0; ackPin = 0;
    expReq = '0; prevLines = '0; expTrig[0] = '0; expTrig[1] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R9 reset state
    check(reqOut === 16'h0, "R9", reqOut, 16'h0);
    readTrig(0, "R9"); readTrig(1, "R9");

    // R6, R7, R11 masked writes, visible after the edge
    cycle(16'h0, 1, 0, 8'hFF, 0, 0, 0, "R11");
    readTrig(0, "R6");
    check(trigRdData === 8'hF8, "R6", {8'h0, trigRdData}, 16'h00F8);
    cycle(16'h0, 1, 1, 8'hFF, 0, 0, 0, "R11");
    readTrig(1, "R7");
    check(trigRdData === 8'hDE, "R7", {8'h0, trigRdData}, 16'h00DE);

    // R2/R5 level line 3 held, ack while high keeps it; R3 fall clears
    cycle(16'h0008, 0, 0, 0, 0, 0, 0, "R2");
    check(reqOut[3] === 1'b1, "R2", reqOut, 16'h0008);
    cycle(16'h0008, 0, 0, 0, 1, 0, 3, "R5");
    check(reqOut[3] === 1'b1, "R5", reqOut, 16'h0008);
    cycle(16'h0000, 0, 0, 0, 0, 0, 0, "R3");
    check(reqOut[3] === 1'b0, "R3", reqOut, 16'h0000);

    // R7/R4 line 8 stays edge despite write of ones; R10 ack ctrl1 pin0
    cycle(16'h0100, 0, 0, 0, 0, 0, 0, "R1");
    cycle(16'h0000, 0, 0, 0, 0, 0, 0, "R4");
    check(reqOut[8] === 1'b1, "R4", reqOut, 16'h0100);
    cycle(16'h0000, 0, 0, 0, 1, 0, 0, "R10");
    check(reqOut[8] === 1'b1, "R10", reqOut, 16'h0100);
    cycle(16'h0000, 0, 0, 0, 1, 1, 0, "R10");
    check(reqOut[8] === 1'b0, "R10", reqOut, 16'h0000);

    // R8 one-cycle pulse on edge line 0
    cycle(16'h0001, 0, 0, 0, 0, 0, 0, "R8");
    cycle(16'h0000, 0, 0, 0, 0, 0, 0, "R8");
    check(reqOut[0] === 1'b1, "R8", reqOut, 16'h0001);
    cycle(16'h0000, 0, 0, 0, 1, 0, 0, "R5");

    // Constrained random mix
    ln = 16'h0;
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] flip;
      flip = 16'($urandom) & 16'($urandom) & 16'($urandom);
      ln = ln ^ flip;
      cycle(ln, ($urandom % 16) == 0, 1'($urandom), 8'($urandom),
            ($urandom % 2) == 0, 1'($urandom), 3'($urandom), "R1");
      if (k % 64 == 0) begin readTrig(0, "R6"); readTrig(1, "R7"); end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule